// File: doc/BRIEF.md
# Time-Base Tap Interval Timer

The block holds a free-running 64-bit time base and watches one bit of it, chosen by software. When that bit rises from 0 to 1, a sticky interval flag in a two-bit status register is set. An interrupt request goes out while that flag, the timer's own enable and a global external-interrupt enable are all high. The tapped bit sets the period, which is a power of two of time-base ticks.

Software programs the block through plain write strobes. One strobe loads the enable bit and a 6-bit tap select, which is built from a 2-bit upper field and a 4-bit lower field. Another strobe clears status bits with a mask, where a 1 clears the matching bit. Each 32-bit half of the time base can also be loaded. The second status bit belongs to a decrementer outside this block: that unit sets the bit through an input pin, and the same mask write clears it. There is no data stream, so every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `tbt_interval_timer`

## Requirements
- R1: On a cycle with `tick_i` high and no load, the time base goes up by one, and it wraps from all ones to zero.
- R2: On a cycle with `tick_i` low and no load, the time base keeps its value.
- R3: `tb_load_i[1]` writes `tb_wdata_i` into bits 63..32 and `tb_load_i[0]` writes it into bits 31..0. Both may be set in the same cycle. Any load overrides the increment for that cycle.
- R4: The tap select is {`ctrl_sel_hi_i`, `ctrl_sel_lo_i`}, taken as a 6-bit value S when `ctrl_we_i` is high. It taps time-base bit 63−S, so S=0 watches bit 63 and S=63 watches bit 0.
- R5: Status bit 0 is set on the clock edge where the tapped bit goes from 0 to 1 under the select held before that edge. A 1-to-0 change or an unchanged bit leaves the flag as it was.
- R6: A load that turns the tapped bit from 0 to 1 sets status bit 0.
- R7: When `stat_we_i` is high, each 1 in `stat_mask_i` clears the matching status bit and each 0 leaves it unchanged. Without a write, a status bit stays as it is unless a set arrives.
- R8: `dec_set_i` sets status bit 1, and the mask rule of R7 clears it. Status bit 1 has no effect on `irq_o`.
- R9: When a set and a mask clear hit the same status bit in the same cycle, the bit ends up 1.
- R10: `irq_o` is high exactly when status bit 0, the stored enable bit and `ext_en_i` are all 1. `irq_o` is combinational in `ext_en_i`.
- R11: While `rst_n` is low, the time base, the enable bit, the tap select and both status bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base count enable |
| tb_load_i | input | 2 | Half-load strobes: bit 1 loads the upper half, bit 0 the lower half |
| tb_wdata_i | input | 32 | Data for a half load |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Interval interrupt enable value |
| ctrl_sel_hi_i | input | 2 | Upper field of the tap select |
| ctrl_sel_lo_i | input | 4 | Lower field of the tap select |
| stat_we_i | input | 1 | Status clear strobe |
| stat_mask_i | input | 2 | Clear mask: bit 0 is the interval flag, bit 1 the decrementer flag |
| dec_set_i | input | 1 | Sets the decrementer status flag |
| ext_en_i | input | 1 | Global external-interrupt enable |
| tb_o | output | 64 | Current time base |
| stat_o | output | 2 | Status flags |
| irq_o | output | 1 | Interval timer interrupt request |

## Verification
The assertions assume the inputs are clean levels sampled at the rising edge, with no undefined values once reset is released. They also assume the tap select changes only through a control write, so the edge check can use the select held one cycle earlier. The bench drives every input at the falling edge to keep within this. It biases the random tap select toward the low-order bits, so that rising edges, set/clear collisions and load-made edges all happen within a short run. Directed sequences cover the outermost taps, a wrap of the time base and a reset in the middle of a run.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int TBT_TB_W   = 64;
  localparam int TBT_HALF_W = 32;
  localparam int TBT_EXT_W  = 2;
  localparam int TBT_PER_W  = 4;
  localparam int TBT_ST_W   = 2;
  localparam int TBT_ST_FI  = 0;
  localparam int TBT_ST_DEC = 1;

  typedef struct packed {
    logic                                 en;
    logic [TBT_EXT_W+TBT_PER_W-1:0]       sel;
  } tbt_ctrl_t;
endpackage

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int TB_W   = tbt_pkg::TBT_TB_W,
  parameter int HALF_W = tbt_pkg::TBT_HALF_W,
  localparam int NHALF = TB_W / HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NHALF-1:0]  load_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [TB_W-1:0]   tb_q_o,
  output logic [TB_W-1:0]   tb_next_o
);
  logic [TB_W-1:0] tb_q;
  logic [TB_W-1:0] loaded;

  // Per-half load mux: each strobe replaces its own slice only
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign loaded[h*HALF_W +: HALF_W] = load_i[h] ? wdata_i : tb_q[h*HALF_W +: HALF_W];

    p_load_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i[h] |=> tb_q[h*HALF_W +: HALF_W] == $past(wdata_i))
      else $error("half load lost");
  end

  always_comb begin
    if (|load_i)      tb_next_o = loaded;
    else if (tick_i)  tb_next_o = tb_q + TB_W'(1);
    else              tb_next_o = tb_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_next_o;
  end

  assign tb_q_o = tb_q;

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && load_i == '0) |=> tb_q == $past(tb_q) + TB_W'(1))
    else $error("time base did not advance");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && load_i == '0) |=> $stable(tb_q))
    else $error("time base moved without tick");
endmodule

// File: rtl/tbt_tap_edge.sv
module tbt_tap_edge #(
  parameter int TB_W  = tbt_pkg::TBT_TB_W,
  localparam int IDX_W = $clog2(TB_W)
) (
  input  logic [TB_W-1:0]  tb_q_i,
  input  logic [TB_W-1:0]  tb_next_i,
  input  logic [IDX_W-1:0] sel_i,
  output logic             rise_o
);
  logic [IDX_W-1:0] idx;
  logic             now_bit;
  logic             nxt_bit;

  // Select counts from the most significant bit downward
  assign idx     = IDX_W'(TB_W - 1) - sel_i;
  assign now_bit = tb_q_i[idx];
  assign nxt_bit = tb_next_i[idx];
  assign rise_o  = nxt_bit & ~now_bit;
endmodule

// File: rtl/tbt_status.sv
module tbt_status #(
  parameter int ST_W = tbt_pkg::TBT_ST_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic            clr_we_i,
  input  logic [ST_W-1:0] clr_mask_i,
  output logic [ST_W-1:0] flags_o
);
  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    logic flag_q;
    logic clr;

    assign clr = clr_we_i & clr_mask_i[b];

    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_i[b]) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
    end

    assign flags_o[b] = flag_q;

    // Applies to both the interval flag and the decrementer flag (R8)
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> flags_o[b])
      else $error("set lost");

    p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_i[b]) |=> !flags_o[b])
      else $error("mask clear ignored");

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set_i[b]) |=> $stable(flags_o[b]))
      else $error("flag changed without cause");
  end
endmodule

// File: rtl/tbt_interval_timer.sv
module tbt_interval_timer #(
  parameter int TB_W   = tbt_pkg::TBT_TB_W,
  parameter int HALF_W = tbt_pkg::TBT_HALF_W,
  parameter int EXT_W  = tbt_pkg::TBT_EXT_W,
  parameter int PER_W  = tbt_pkg::TBT_PER_W,
  localparam int NHALF = TB_W / HALF_W,
  localparam int SEL_W = EXT_W + PER_W,
  localparam int ST_W  = tbt_pkg::TBT_ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NHALF-1:0]  tb_load_i,
  input  logic [HALF_W-1:0] tb_wdata_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic [EXT_W-1:0]  ctrl_sel_hi_i,
  input  logic [PER_W-1:0]  ctrl_sel_lo_i,
  input  logic              stat_we_i,
  input  logic [ST_W-1:0]   stat_mask_i,
  input  logic              dec_set_i,
  input  logic              ext_en_i,
  output logic [TB_W-1:0]   tb_o,
  output logic [ST_W-1:0]   stat_o,
  output logic              irq_o
);
  import tbt_pkg::*;

  tbt_ctrl_t        ctrl_q;
  logic [TB_W-1:0]  tb_q;
  logic [TB_W-1:0]  tb_next;
  logic             fi_rise;
  logic [ST_W-1:0]  st_set;
  logic [SEL_W-1:0] tap_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= '{en: ctrl_en_i, sel: {ctrl_sel_hi_i, ctrl_sel_lo_i}};
  end

  tbt_timebase #(.TB_W(TB_W), .HALF_W(HALF_W)) i_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .load_i    (tb_load_i),
    .wdata_i   (tb_wdata_i),
    .tb_q_o    (tb_q),
    .tb_next_o (tb_next)
  );

  tbt_tap_edge #(.TB_W(TB_W)) i_tap_edge (
    .tb_q_i    (tb_q),
    .tb_next_i (tb_next),
    .sel_i     (ctrl_q.sel),
    .rise_o    (fi_rise)
  );

  always_comb begin
    st_set             = '0;
    st_set[TBT_ST_FI]  = fi_rise;
    st_set[TBT_ST_DEC] = dec_set_i;
  end

  tbt_status #(.ST_W(ST_W)) i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (st_set),
    .clr_we_i   (stat_we_i),
    .clr_mask_i (stat_mask_i),
    .flags_o    (stat_o)
  );

  assign tb_o    = tb_q;
  assign irq_o   = stat_o[TBT_ST_FI] & ctrl_q.en & ext_en_i;
  assign tap_idx = SEL_W'(TB_W - 1) - ctrl_q.sel;

  // The interval flag only ever rises on a 0-to-1 step of the watched bit
  p_tap_rose_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[TBT_ST_FI]) |-> (tb_q[$past(tap_idx)] && !$past(tb_q[tap_idx])))
    else $error("flag rose without tap edge");

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en_i || !ctrl_q.en) |-> !irq_o)
    else $error("irq without enables");

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> stat_o[TBT_ST_FI])
    else $error("irq without flag");
endmodule

// File: tb/test_tbt_interval_timer.sv
module test_tbt_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  tb_load_i = '0;
  logic [31:0] tb_wdata_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic        ctrl_en_i = 1'b0;
  logic [1:0]  ctrl_sel_hi_i = '0;
  logic [3:0]  ctrl_sel_lo_i = '0;
  logic        stat_we_i = 1'b0;
  logic [1:0]  stat_mask_i = '0;
  logic        dec_set_i = 1'b0;
  logic        ext_en_i = 1'b0;
  logic [63:0] tb_o;
  logic [1:0]  stat_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_tb;
  logic [5:0]  m_sel;
  logic        m_en;
  logic        m_fi;
  logic        m_dec;

  always #2 clk = ~clk;

  tbt_interval_timer i_tbt_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tb_load_i(tb_load_i),
    .tb_wdata_i(tb_wdata_i), .ctrl_we_i(ctrl_we_i), .ctrl_en_i(ctrl_en_i),
    .ctrl_sel_hi_i(ctrl_sel_hi_i), .ctrl_sel_lo_i(ctrl_sel_lo_i),
    .stat_we_i(stat_we_i), .stat_mask_i(stat_mask_i), .dec_set_i(dec_set_i),
    .ext_en_i(ext_en_i), .tb_o(tb_o), .stat_o(stat_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] next_tb(logic [63:0] tb, logic [1:0] ld,
                                          logic [31:0] wd, logic tk);
    logic [63:0] r;
    r = tb;
    if (ld[1]) r[63:32] = wd;
    if (ld[0]) r[31:0]  = wd;
    if (ld == 2'b00 && tk) r = tb + 64'd1;
    return r;
  endfunction

  function automatic logic tap(logic [63:0] tb, logic [5:0] sel);
    return tb[6'd63 - sel];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check({tag, " tb"}, tb_o, m_tb);
    check({tag, " status"}, 64'(stat_o), 64'({m_dec, m_fi}));
    check({tag, " irq R10"}, 64'(irq_o), 64'(m_fi & m_en & ext_en_i));
  endtask

  task automatic model_reset();
    m_tb = '0; m_sel = '0; m_en = 1'b0; m_fi = 1'b0; m_dec = 1'b0;
  endtask

  // Inputs are set by the caller at a falling edge; one clock is applied here
  task automatic step(string tag);
    logic [63:0] nx;
    logic        rise;
    @(posedge clk);
    nx   = next_tb(m_tb, tb_load_i, tb_wdata_i, tick_i);
    rise = tap(nx, m_sel) & ~tap(m_tb, m_sel);
    m_fi  = rise | (m_fi & ~(stat_we_i & stat_mask_i[0]));
    m_dec = dec_set_i | (m_dec & ~(stat_we_i & stat_mask_i[1]));
    if (ctrl_we_i) begin
      m_en  = ctrl_en_i;
      m_sel = {ctrl_sel_hi_i, ctrl_sel_lo_i};
    end
    m_tb = nx;
    #1;
    compare_all(tag);
    @(negedge clk);
    tick_i = 1'b0; tb_load_i = '0; ctrl_we_i = 1'b0;
    stat_we_i = 1'b0; stat_mask_i = '0; dec_set_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    compare_all("R11 reset");
  endtask

  task automatic set_ctrl(logic en, logic [5:0] sel);
    ctrl_we_i = 1'b1; ctrl_en_i = en;
    ctrl_sel_hi_i = sel[5:4]; ctrl_sel_lo_i = sel[3:0];
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R2: no tick, no change
    step("R2 idle");
    // R1: count a few ticks
    repeat (3) begin tick_i = 1'b1; step("R1 count"); end

    // R4: select 63 watches bit 0; tb=3 -> bit0 falls, then rises
    set_ctrl(1'b1, 6'd63); step("R4 sel63 write");
    tick_i = 1'b1; step("R5 falling bit no set");
    tick_i = 1'b1; ext_en_i = 1'b1; step("R4 sel63 rise");
    ext_en_i = 1'b0; step("R10 ext off");
    ext_en_i = 1'b1; set_ctrl(1'b0, 6'd63); step("R10 en off");
    set_ctrl(1'b1, 6'd63); step("R10 all on");

    // R7: mask 0 on fi bit leaves it; dec flag R8
    stat_we_i = 1'b1; stat_mask_i = 2'b10; step("R7 mask zero keeps");
    dec_set_i = 1'b1; step("R8 dec set");
    stat_we_i = 1'b1; stat_mask_i = 2'b01; step("R7 clear fi only");
    stat_we_i = 1'b1; stat_mask_i = 2'b10; step("R8 clear dec");

    // R9: set and clear together on both bits
    tick_i = 1'b1; step("R1 to even");
    tick_i = 1'b1; dec_set_i = 1'b1; stat_we_i = 1'b1; stat_mask_i = 2'b11;
    step("R9 set beats clear");
    stat_we_i = 1'b1; stat_mask_i = 2'b11; step("R7 clear both");

    // R4: select 0 watches bit 63; R3 load upper then tick across
    set_ctrl(1'b1, 6'd0); step("R4 sel0 write");
    tb_load_i = 2'b11; tb_wdata_i = 32'h7FFF_FFFF; step("R3 both halves");
    tb_load_i = 2'b01; tb_wdata_i = 32'hFFFF_FFFF; tick_i = 1'b1; step("R3 load beats tick");
    tick_i = 1'b1; step("R4 sel0 rise bit63");
    stat_we_i = 1'b1; stat_mask_i = 2'b01; step("R7 clear");

    // R1 wrap: all ones to zero, bit63 falls -> R5 no set
    tb_load_i = 2'b11; tb_wdata_i = 32'hFFFF_FFFF; step("R3 load ones");
    tick_i = 1'b1; step("R1 wrap no set R5");

    // R6: load sets the tapped bit; select split field: hi=01, lo=0 -> bit 47
    set_ctrl(1'b1, 6'd16); step("R4 split select");
    tb_load_i = 2'b10; tb_wdata_i = 32'h0000_8000; step("R6 load edge bit47");
    stat_we_i = 1'b1; stat_mask_i = 2'b01; step("R7 clear");
    tb_load_i = 2'b10; tb_wdata_i = 32'h0000_8000; step("R6 level held no set");

    // R11: reset mid-run clears control too
    do_reset();
    tb_load_i = 2'b10; tb_wdata_i = 32'h8000_0000; step("R11 en cleared");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      tick_i = ($urandom % 4) != 0;
      if ($urandom % 24 == 0) begin
        tb_load_i  = 2'($urandom);
        tb_wdata_i = ($urandom % 2) ? $urandom : 32'($urandom % 64);
      end
      if ($urandom % 16 == 0)
        set_ctrl(1'($urandom), ($urandom % 8 == 0) ? 6'($urandom) : 6'(58 + $urandom % 6));
      if ($urandom % 6 == 0) begin
        stat_we_i = 1'b1; stat_mask_i = 2'($urandom);
      end
      dec_set_i = ($urandom % 12) == 0;
      if ($urandom % 10 == 0) ext_en_i = 1'($urandom);
      step("R5 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule